// File: doc/BRIEF.md
# Panel Power-Up Command Sequencer

This block brings a command-mode display panel from cold reset to a lit state without software involvement. After a `start` pulse it pulls the panel's active-low reset pin low, releases it, and lets the panel controller settle. It then hands a fixed series of display command bytes to a downstream link controller. The bytes are a soft reset, a pixel-format selection of 24 bits per pixel, a sleep exit and a display-on. Each command or parameter byte crosses a valid/ready byte port. A marker flags the opening byte of each command.

Every wait is counted in clock cycles. The cycle count is worked out from a clock-frequency parameter and a millisecond figure for that step, so one netlist serves any clock rate. Each timed wait after a command starts at the cycle in which the link takes that byte, so a slow link stretches the sequence but never shortens a settle time. When the link takes the display-on byte, `done` rises and stays high. It drops on the next `start` or on reset.

Top module: `panel_boot_seq`

## Requirements
- R1: After `rst`, `panel_rst_n` is 0, `tx_valid` is 0 and `done` is 0. They stay so, with no byte offered, until `start` is sampled high.
- R2: When `start` is sampled high in idle or finished state, `panel_rst_n` is 0 for exactly RST_LOW_MS*CLK_HZ/1000 cycles after that edge and then goes to 1. While it is 0, no byte is offered.
- R3: The first byte is the soft-reset command 0x01 with `tx_first`=1. It is first offered exactly (RST_LOW_MS+RST_SETTLE_MS)*CLK_HZ/1000 cycles after the start edge.
- R4: A byte transfers only on a cycle where `tx_valid` and `tx_ready` are both 1. While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_first` hold their values into the next cycle.
- R5: After the soft-reset byte is taken, `tx_valid` is 0 for exactly SWRST_WAIT_MS*CLK_HZ/1000 cycles. Then the pixel-format command 0x3A is offered with `tx_first`=1.
- R6: The cycle after 0x3A is taken, its parameter 0x77 is offered with `tx_first`=0.
- R7: The cycle after 0x77 is taken, the sleep-exit command 0x11 is offered with `tx_first`=1.
- R8: After 0x11 is taken, `tx_valid` is 0 for exactly WAKE_WAIT_MS*CLK_HZ/1000 cycles. Then the display-on command 0x29 is offered with `tx_first`=1.
- R9: The cycle after 0x29 is taken, `done` is 1 and `tx_valid` is 0. Both hold, with `panel_rst_n` at 1, until the next `start` or `rst`.
- R10: `start` sampled high while `done` is 1 clears `done` and runs the whole sequence again from R2.
- R11: `rst` sampled high at any point in the sequence returns the block to the R1 state on the next cycle.
- R12: `start` sampled high while a sequence is running is ignored. The timing of R2 to R8 is measured from the start that began the run.
- R13: A stall on `tx_ready` delays the later steps. Every wait counts from the cycle the previous byte was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the power-up sequence when idle or finished |
| tx_ready | input | 1 | Link controller can take the offered byte |
| panel_rst_n | output | 1 | Active-low reset pin to the panel |
| tx_valid | output | 1 | A byte is offered on `tx_data` |
| tx_data | output | 8 | Command or parameter byte |
| tx_first | output | 1 | 1 on a command byte, 0 on a parameter byte |
| done | output | 1 | Panel initialisation complete |

## Verification
The assertions take for granted that `tx_ready` is a plain level from the link. It may rise or fall on any cycle, including while no byte is offered. They also assume `rst` and `start` are synchronous single-bit inputs. The stimulus drives all of these only on falling clock edges. It holds `tx_ready` low for several cycles before some bytes and raises it for exactly one cycle per byte. It pulses `start` both during a settle wait and after completion, so the hold and ordering properties are tried under stalls and redundant starts. The bench uses a clock parameter of 10 kHz, so each millisecond is ten cycles.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  localparam logic [7:0] CMD_SOFT_RESET = 8'h01;
  localparam logic [7:0] CMD_PIXEL_FMT  = 8'h3A;
  localparam logic [7:0] ARG_RGB24      = 8'h77;
  localparam logic [7:0] CMD_WAKE       = 8'h11;
  localparam logic [7:0] CMD_LIGHT_ON   = 8'h29;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_HOLD,
    ST_RST_SETTLE,
    ST_TX_SWRST,
    ST_WAIT_SWRST,
    ST_TX_FMT,
    ST_TX_FMT_ARG,
    ST_TX_WAKE,
    ST_WAIT_WAKE,
    ST_TX_LIGHT,
    ST_ON
  } seq_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       first;
  } link_byte_t;

  function automatic link_byte_t byte_for(seq_state_e s);
    link_byte_t b;
    b = '{data: 8'h00, first: 1'b0};
    case (s)
      ST_TX_SWRST:   b = '{data: CMD_SOFT_RESET, first: 1'b1};
      ST_TX_FMT:     b = '{data: CMD_PIXEL_FMT,  first: 1'b1};
      ST_TX_FMT_ARG: b = '{data: ARG_RGB24,      first: 1'b0};
      ST_TX_WAKE:    b = '{data: CMD_WAKE,       first: 1'b1};
      ST_TX_LIGHT:   b = '{data: CMD_LIGHT_ON,   first: 1'b1};
      default:       b = '{data: 8'h00,          first: 1'b0};
    endcase
    return b;
  endfunction

endpackage

// File: rtl/pbs_delay_timer.sv
module pbs_delay_timer #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic             expired
);

  logic [WIDTH-1:0] count_q;
  logic             running_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      running_q <= 1'b0;
    end else if (load) begin
      count_q   <= load_val;
      running_q <= 1'b1;
    end else if (running_q) begin
      if (count_q == '0) begin
        running_q <= 1'b0;
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  assign expired = running_q && (count_q == '0);

endmodule

// File: rtl/pbs_byte_emitter.sv
module pbs_byte_emitter
  import pbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  link_byte_t load_byte,
  input  logic       ready,
  output logic       valid,
  output logic [7:0] data,
  output logic       first,
  output logic       accepted
);

  logic       valid_q;
  link_byte_t byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      byte_q  <= '{data: 8'h00, first: 1'b0};
    end else if (load) begin
      valid_q <= 1'b1;
      byte_q  <= load_byte;
    end else if (valid_q && ready) begin
      valid_q <= 1'b0;
    end
  end

  assign valid    = valid_q;
  assign data     = byte_q.data;
  assign first    = byte_q.first;
  assign accepted = valid_q && ready;

endmodule

// File: rtl/pbs_step_ctrl.sv
module pbs_step_ctrl
  import pbs_pkg::*;
#(
  parameter int TW           = 24,
  parameter int HOLD_TICKS   = 10,
  parameter int SETTLE_TICKS = 120,
  parameter int SWRST_TICKS  = 5,
  parameter int WAKE_TICKS   = 120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          tmr_expired,
  input  logic          byte_taken,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          byte_load,
  output link_byte_t    byte_sel,
  output logic          panel_rst_n,
  output logic          done
);

  localparam logic [TW-1:0] HOLD_LOAD   = TW'(HOLD_TICKS - 1);
  localparam logic [TW-1:0] SETTLE_LOAD = TW'(SETTLE_TICKS - 1);
  localparam logic [TW-1:0] SWRST_LOAD  = TW'(SWRST_TICKS - 1);
  localparam logic [TW-1:0] WAKE_LOAD   = TW'(WAKE_TICKS - 1);

  seq_state_e st_q, st_d;
  logic       launch;

  assign launch = start && (st_q == ST_IDLE || st_q == ST_ON);

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    byte_load = 1'b0;
    case (st_q)
      ST_IDLE, ST_ON: begin
        if (start) begin
          st_d     = ST_RST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LOAD;
        end
      end
      ST_RST_HOLD: begin
        if (tmr_expired) begin
          st_d     = ST_RST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LOAD;
        end
      end
      ST_RST_SETTLE: begin
        if (tmr_expired) begin
          st_d      = ST_TX_SWRST;
          byte_load = 1'b1;
        end
      end
      ST_TX_SWRST: begin
        if (byte_taken) begin
          st_d     = ST_WAIT_SWRST;
          tmr_load = 1'b1;
          tmr_val  = SWRST_LOAD;
        end
      end
      ST_WAIT_SWRST: begin
        if (tmr_expired) begin
          st_d      = ST_TX_FMT;
          byte_load = 1'b1;
        end
      end
      ST_TX_FMT: begin
        if (byte_taken) begin
          st_d      = ST_TX_FMT_ARG;
          byte_load = 1'b1;
        end
      end
      ST_TX_FMT_ARG: begin
        if (byte_taken) begin
          st_d      = ST_TX_WAKE;
          byte_load = 1'b1;
        end
      end
      ST_TX_WAKE: begin
        if (byte_taken) begin
          st_d     = ST_WAIT_WAKE;
          tmr_load = 1'b1;
          tmr_val  = WAKE_LOAD;
        end
      end
      ST_WAIT_WAKE: begin
        if (tmr_expired) begin
          st_d      = ST_TX_LIGHT;
          byte_load = 1'b1;
        end
      end
      ST_TX_LIGHT: begin
        if (byte_taken) begin
          st_d = ST_ON;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign byte_sel = byte_for(st_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      panel_rst_n <= 1'b0;
      done        <= 1'b0;
    end else begin
      st_q <= st_d;
      if (launch) begin
        panel_rst_n <= 1'b0;
        done        <= 1'b0;
      end else begin
        if (st_q == ST_RST_HOLD && tmr_expired) begin
          panel_rst_n <= 1'b1;
        end
        if (st_q == ST_TX_LIGHT && byte_taken) begin
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/panel_boot_seq.sv
module panel_boot_seq
  import pbs_pkg::*;
#(
  parameter int CLK_HZ          = 100_000_000,
  parameter int RST_LOW_MS      = 10,
  parameter int RST_SETTLE_MS   = 120,
  parameter int SWRST_WAIT_MS   = 5,
  parameter int WAKE_WAIT_MS    = 120
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       tx_ready,
  output logic       panel_rst_n,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_first,
  output logic       done
);

  localparam int TICKS_PER_MS = CLK_HZ / 1000;
  localparam int HOLD_TICKS   = RST_LOW_MS * TICKS_PER_MS;
  localparam int SETTLE_TICKS = RST_SETTLE_MS * TICKS_PER_MS;
  localparam int SWRST_TICKS  = SWRST_WAIT_MS * TICKS_PER_MS;
  localparam int WAKE_TICKS   = WAKE_WAIT_MS * TICKS_PER_MS;
  localparam int MAX_A        = (HOLD_TICKS > SETTLE_TICKS) ? HOLD_TICKS : SETTLE_TICKS;
  localparam int MAX_B        = (SWRST_TICKS > WAKE_TICKS) ? SWRST_TICKS : WAKE_TICKS;
  localparam int MAX_TICKS    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW           = (MAX_TICKS < 2) ? 1 : $clog2(MAX_TICKS);

  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expired;
  logic          byte_load;
  link_byte_t    byte_sel;
  logic          byte_taken;

  pbs_step_ctrl #(
    .TW          (TW),
    .HOLD_TICKS  (HOLD_TICKS),
    .SETTLE_TICKS(SETTLE_TICKS),
    .SWRST_TICKS (SWRST_TICKS),
    .WAKE_TICKS  (WAKE_TICKS)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .tmr_expired(tmr_expired),
    .byte_taken (byte_taken),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .byte_load  (byte_load),
    .byte_sel   (byte_sel),
    .panel_rst_n(panel_rst_n),
    .done       (done)
  );

  pbs_delay_timer #(
    .WIDTH(TW)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  pbs_byte_emitter u_emit (
    .clk      (clk),
    .rst      (rst),
    .load     (byte_load),
    .load_byte(byte_sel),
    .ready    (tx_ready),
    .valid    (tx_valid),
    .data     (tx_data),
    .first    (tx_first),
    .accepted (byte_taken)
  );

endmodule

// File: rtl/panel_boot_seq_chk.sv
module panel_boot_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_ready,
  input logic       panel_rst_n,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_first,
  input logic       done
);

  // R4
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_first)));

  // R2
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !panel_rst_n |-> !tx_valid);

  // R6
  fmt_arg_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_first && tx_data == 8'h3A)
      |=> (tx_valid && !tx_first && tx_data == 8'h77));

  // R7
  wake_follows_arg_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !tx_first && tx_data == 8'h77)
      |=> (tx_valid && tx_first && tx_data == 8'h11));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!tx_valid && panel_rst_n));

  // R9
  done_after_light_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(tx_valid && tx_ready && tx_first && tx_data == 8'h29));

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!panel_rst_n && !tx_valid && !done));

endmodule

bind panel_boot_seq panel_boot_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_ready   (tx_ready),
  .panel_rst_n(panel_rst_n),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .tx_first   (tx_first),
  .done       (done)
);

// File: tb/sim_panel_boot_seq.sv
`timescale 1ns/1ps
module sim_panel_boot_seq;

  localparam int T     = 10;
  localparam int LIMIT = 4000;

  typedef struct packed {
    logic [7:0]  d;
    logic        f;
    int unsigned gap;
    int unsigned stall;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'h01, 1'b1, 130*T, 3},
    '{8'h3A, 1'b1, 5*T,   0},
    '{8'h77, 1'b0, 0,     2},
    '{8'h11, 1'b1, 0,     0},
    '{8'h29, 1'b1, 120*T, 5}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       tx_ready = 1'b0;
  logic       panel_rst_n;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_first;
  logic       done;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  panel_boot_seq #(.CLK_HZ(10_000)) u0 (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .tx_ready   (tx_ready),
    .panel_rst_n(panel_rst_n),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_first   (tx_first),
    .done       (done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int gap;
    int lows;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, and idle while start is low
    chk("R1 pin", panel_rst_n, 0);
    chk("R1 valid", tx_valid, 0);
    chk("R1 done", done, 0);
    repeat (8) @(negedge clk);
    chk("R1 idle valid", tx_valid, 0);
    chk("R1 idle pin", panel_rst_n, 0);

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      gap  = 0;
      lows = 0;
      while (!tx_valid && gap < LIMIT) begin
        if (!panel_rst_n) lows++;
        gap++;
        @(negedge clk);
      end
      // R3 R5 R6 R7 R8: gap before each byte
      chk($sformatf("R3/R5/R8 gap byte %0d", i), gap, VEC[i].gap);
      if (i == 0) chk("R2 reset low cycles", lows, 10*T);
      else        chk("R2 pin high after release", lows, 0);
      chk($sformatf("R6/R7 data byte %0d", i), tx_data, VEC[i].d);
      chk($sformatf("R6 first flag byte %0d", i), tx_first, VEC[i].f);
      for (int s = 0; s < int'(VEC[i].stall); s++) begin
        @(negedge clk);
        // R4 R13: held while stalled
        chk("R4 held valid", tx_valid, 1);
        chk("R4 held data", tx_data, VEC[i].d);
      end
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
    // R9
    chk("R9 done", done, 1);
    chk("R9 valid low", tx_valid, 0);
    repeat (10) @(negedge clk);
    chk("R9 done holds", done, 1);
    chk("R9 pin high", panel_rst_n, 1);

    // R10 restart from done, R12 redundant start during settle
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 done cleared", done, 0);
    chk("R10 pin low", panel_rst_n, 0);
    gap = 0;
    while (!tx_valid && gap < LIMIT) begin
      start = (gap == 60*T);
      gap++;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R12 start ignored gap", gap, 130*T);
    chk("R12 first byte", tx_data, 8'h01);

    // R11 reset mid-sequence
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 pin", panel_rst_n, 0);
    chk("R11 valid", tx_valid, 0);
    chk("R11 done", done, 0);
    repeat (20) @(negedge clk);
    chk("R11 stays idle", tx_valid, 0);
    finish_run();
  end

endmodule